// File: doc/BRIEF.md
# DMA Channel Arm, Trigger and Completion Control

This block is the control side of a small multi-channel DMA engine. Each channel holds its own configuration: a trigger code, a transfer length and an interrupt mask bit. It also holds an armed bit, a pending request and a count of the transfers it has done. Each trigger that reaches an armed channel produces one transfer strobe. When a channel has made as many transfers as its length asks for, it disarms itself, raises its bit in a sticky completion register and, if its mask allows, raises a CPU-level DMA flag.

Trigger sources are selected per channel by code:
- a software request;
- the completion of the next-lower channel;
- a vector of peripheral event pulses;
- two external pins, which are synchronised and edge-detected, one on its rising edge and one on its falling edge.

When several channels want a strobe in the same cycle, a fixed-priority arbiter grants one channel per cycle. The address generation and the data movement sit outside this block and act on the strobes.

Top module: `dma_trig_ctrl`

## Requirements
- R1: A write to the arm port with bit 7 clear sets the armed bit of every channel whose bit is 1 and leaves the rest unchanged. Writing 0x03 arms channels 0 and 1.
- R2: A write with bit 7 set disarms only the channels whose bits are 1 and also drops any request they have pending. Writing 0x81 disarms channel 0 and leaves channel 1 armed.
- R3: A trigger or software request that reaches an unarmed channel is ignored. No strobe follows, not even after the channel is armed later.
- R4: With trigger code 0, no hardware event starts a channel. A software request bit, sampled at a clock edge, gives a one-cycle strobe after the next edge. A software request starts any armed channel.
- R5: Code 1 triggers channel i when channel i-1 completes, so the strobe comes two cycles after that channel's final strobe. Channel 0 with code 1 never fires.
- R6: Codes 2 to 13 select peripheral_trig_i[code-2]. Codes 16 to 31 never fire.
- R7: Code 14 fires on a rising edge of pin_rise_i and code 15 on a falling edge of pin_fall_i. Each pin goes through a two-flop synchroniser, so the strobe comes four edges after the pin changes. Holding a level does not fire again.
- R8: A channel completes on the strobe that brings its transfer count to its length (lengths 0 and 1 both complete on the first strobe). On completion the channel disarms.
- R9: A channel's completion flag is set on the completion strobe whatever its mask bit. It stays set until a write-one-to-clear, and a clear in the same cycle as a new completion leaves it set.
- R10: The DMA flag is set on completion only for a channel whose mask bit is 1. It stays set until cpu_flag_clr_i. irq_o is the flag gated by irq_en_i.
- R11: When several channels are pending, the lowest-numbered one is strobed first. The others follow one per cycle, and at most one strobe is high at a time.
- R12: After reset, no channel is armed, and all strobes, completion flags, the DMA flag and the interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm_wr_i | input | 1 | Arm register write strobe |
| arm_data_i | input | NCH+1 | Channel select bits; MSB set means abort |
| swreq_wr_i | input | 1 | Software request write strobe |
| swreq_i | input | NCH | Software request bit per channel |
| cfg_wr_i | input | 1 | Channel configuration write strobe |
| cfg_ch_i | input | clog2(NCH) | Channel being configured |
| cfg_trig_i | input | TRIG_W | Trigger code |
| cfg_len_i | input | CNT_W | Transfer length |
| cfg_msk_i | input | 1 | Interrupt mask bit (1 = raise DMA flag) |
| flag_clr_wr_i | input | 1 | Completion flag clear strobe |
| flag_clr_i | input | NCH | Write-one-to-clear bits for completion flags |
| cpu_flag_clr_i | input | 1 | Clears the DMA flag |
| irq_en_i | input | 1 | DMA interrupt enable |
| periph_trig_i | input | NPERIPH | Peripheral event pulses |
| pin_rise_i | input | 1 | Asynchronous pin, rising-edge trigger |
| pin_fall_i | input | 1 | Asynchronous pin, falling-edge trigger |
| xfer_strobe_o | output | NCH | One-cycle transfer strobe per channel |
| armed_o | output | NCH | Armed state per channel |
| done_flags_o | output | NCH | Sticky completion flags |
| dma_flag_o | output | 1 | CPU-level DMA flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a pending request that is aborted before it is served. Requests are granted one cycle after they arrive, so the stimulus gets there by raising a request on channel 3 together with one on channel 0. Channel 0 holds the grant for a cycle, and the abort write lands in that cycle. The second is a flag clear that meets a completion in the same cycle: the clear is timed to the edge on which the final strobe is registered.

// File: rtl/dma_trig_ctrl_pkg.sv
package dma_trig_ctrl_pkg;
  localparam int TRIG_NONE        = 0;
  localparam int TRIG_PREV        = 1;
  localparam int TRIG_PERIPH_BASE = 2;

  function automatic int pin_rise_code(input int nperiph);
    return TRIG_PERIPH_BASE + nperiph;
  endfunction

  function automatic int pin_fall_code(input int nperiph);
    return TRIG_PERIPH_BASE + nperiph + 1;
  endfunction
endpackage

// File: rtl/dma_trig_ctrl_rst_sync.sv
module dma_trig_ctrl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dma_trig_ctrl_edge.sv
module dma_trig_ctrl_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic evt_o
);
  logic [2:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[1:0], pin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b000;
    else        sync_q <= sync_d;
  end

  // sync_q[1] is the second synchroniser stage, sync_q[2] its delayed copy
  generate
    if (RISING) begin : g_rise
      assign evt_o = sync_q[1] & ~sync_q[2];
    end else begin : g_fall
      assign evt_o = ~sync_q[1] & sync_q[2];
    end
  endgenerate
endmodule

// File: rtl/dma_trig_ctrl_mux.sv
module dma_trig_ctrl_mux
  import dma_trig_ctrl_pkg::*;
#(
  parameter int TRIG_W  = 5,
  parameter int NPERIPH = 12
) (
  input  logic [TRIG_W-1:0]  trig_num_i,
  input  logic               prev_done_i,
  input  logic [NPERIPH-1:0] periph_i,
  input  logic               pin_rise_evt_i,
  input  logic               pin_fall_evt_i,
  output logic               hit_o
);
  localparam int RISE_CODE = pin_rise_code(NPERIPH);
  localparam int FALL_CODE = pin_fall_code(NPERIPH);

  always_comb begin
    hit_o = 1'b0;
    if (trig_num_i == TRIG_W'(TRIG_PREV)) hit_o = prev_done_i;
    if (trig_num_i == TRIG_W'(RISE_CODE)) hit_o = pin_rise_evt_i;
    if (trig_num_i == TRIG_W'(FALL_CODE)) hit_o = pin_fall_evt_i;
    for (int k = 0; k < NPERIPH; k++) begin
      if (trig_num_i == TRIG_W'(TRIG_PERIPH_BASE + k)) hit_o = periph_i[k];
    end
  end
endmodule

// File: rtl/dma_trig_ctrl_chan.sv
module dma_trig_ctrl_chan #(
  parameter int TRIG_W = 5,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [TRIG_W-1:0] cfg_trig_i,
  input  logic [CNT_W-1:0]  cfg_len_i,
  input  logic              cfg_msk_i,
  input  logic              arm_set_i,
  input  logic              arm_clr_i,
  input  logic              start_i,
  input  logic              grant_i,
  output logic [TRIG_W-1:0] trig_num_o,
  output logic              msk_o,
  output logic              armed_o,
  output logic              pend_o,
  output logic              done_o
);
  logic              armed_q, armed_d, pend_q, pend_d, msk_q, msk_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, len_q, len_d;
  logic [TRIG_W-1:0] trig_q, trig_d;
  logic [CNT_W:0]    cnt_nx;
  logic              last, state_en;

  assign cnt_nx   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign last     = grant_i & (cnt_nx >= {1'b0, len_q});
  assign state_en = grant_i | start_i | arm_set_i | arm_clr_i | cfg_we_i;

  always_comb begin
    armed_d = armed_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    trig_d  = trig_q;
    len_d   = len_q;
    msk_d   = msk_q;
    if (grant_i) begin
      pend_d = 1'b0;
      cnt_d  = last ? '0 : cnt_nx[CNT_W-1:0];
    end
    if (armed_q && start_i && !last) pend_d = 1'b1;
    if (last) armed_d = 1'b0;
    if (arm_set_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end
    if (arm_clr_i) begin
      armed_d = 1'b0;
      pend_d  = 1'b0;
    end
    if (cfg_we_i) begin
      trig_d = cfg_trig_i;
      len_d  = cfg_len_i;
      msk_d  = cfg_msk_i;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      trig_q  <= '0;
      len_q   <= '0;
      msk_q   <= 1'b0;
    end else if (state_en) begin
      armed_q <= armed_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
      trig_q  <= trig_d;
      len_q   <= len_d;
      msk_q   <= msk_d;
    end
  end

  assign trig_num_o = trig_q;
  assign msk_o      = msk_q;
  assign armed_o    = armed_q;
  assign pend_o     = pend_q;
  assign done_o     = last;
endmodule

// File: rtl/dma_trig_ctrl_arb.sv
module dma_trig_ctrl_arb #(
  parameter int NCH = 7
) (
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = NCH'(1) << i;
    end
  end
endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl #(
  parameter  int NCH     = 7,
  parameter  int CNT_W   = 8,
  parameter  int TRIG_W  = 5,
  parameter  int NPERIPH = 12,
  localparam int CH_W    = $clog2(NCH),
  localparam int ARM_W   = NCH + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_wr_i,
  input  logic [ARM_W-1:0]   arm_data_i,
  input  logic               swreq_wr_i,
  input  logic [NCH-1:0]     swreq_i,
  input  logic               cfg_wr_i,
  input  logic [CH_W-1:0]    cfg_ch_i,
  input  logic [TRIG_W-1:0]  cfg_trig_i,
  input  logic [CNT_W-1:0]   cfg_len_i,
  input  logic               cfg_msk_i,
  input  logic               flag_clr_wr_i,
  input  logic [NCH-1:0]     flag_clr_i,
  input  logic               cpu_flag_clr_i,
  input  logic               irq_en_i,
  input  logic [NPERIPH-1:0] periph_trig_i,
  input  logic               pin_rise_i,
  input  logic               pin_fall_i,
  output logic [NCH-1:0]     xfer_strobe_o,
  output logic [NCH-1:0]     armed_o,
  output logic [NCH-1:0]     done_flags_o,
  output logic               dma_flag_o,
  output logic               irq_o
);
  logic           rst_sync_n;
  logic           rise_evt, fall_evt, abort;
  logic [NCH-1:0] pend, gnt, done, msk, start, hw_hit;
  logic [NCH-1:0] strobe_q, strobe_d, done_q, done_d, flags_q, flags_d, clr_mask;
  logic           dflag_q, dflag_d;

  dma_trig_ctrl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  dma_trig_ctrl_edge #(.RISING(1'b1)) u_rise (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(pin_rise_i), .evt_o(rise_evt));
  dma_trig_ctrl_edge #(.RISING(1'b0)) u_fall (
    .clk(clk), .rst_n(rst_sync_n), .pin_i(pin_fall_i), .evt_o(fall_evt));

  assign abort = arm_data_i[ARM_W-1];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [TRIG_W-1:0] trig_num;
    logic              prev_done;

    if (i == 0) begin : g_first
      assign prev_done = 1'b0;
    end else begin : g_chain
      assign prev_done = done_q[i-1];
    end

    dma_trig_ctrl_mux #(.TRIG_W(TRIG_W), .NPERIPH(NPERIPH)) u_mux (
      .trig_num_i(trig_num), .prev_done_i(prev_done), .periph_i(periph_trig_i),
      .pin_rise_evt_i(rise_evt), .pin_fall_evt_i(fall_evt), .hit_o(hw_hit[i]));

    assign start[i] = hw_hit[i] | (swreq_wr_i & swreq_i[i]);

    dma_trig_ctrl_chan #(.TRIG_W(TRIG_W), .CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_sync_n),
      .cfg_we_i(cfg_wr_i && (cfg_ch_i == CH_W'(i))),
      .cfg_trig_i(cfg_trig_i), .cfg_len_i(cfg_len_i), .cfg_msk_i(cfg_msk_i),
      .arm_set_i(arm_wr_i & ~abort & arm_data_i[i]),
      .arm_clr_i(arm_wr_i & abort & arm_data_i[i]),
      .start_i(start[i]), .grant_i(gnt[i]),
      .trig_num_o(trig_num), .msk_o(msk[i]), .armed_o(armed_o[i]),
      .pend_o(pend[i]), .done_o(done[i]));
  end

  dma_trig_ctrl_arb #(.NCH(NCH)) u_arb (.req_i(pend), .gnt_o(gnt));

  always_comb begin
    clr_mask = flag_clr_wr_i ? flag_clr_i : '0;
    strobe_d = gnt;
    done_d   = done;
    flags_d  = (flags_q & ~clr_mask) | done;
    dflag_d  = (dflag_q & ~cpu_flag_clr_i) | (|(done & msk));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      strobe_q <= '0;
      done_q   <= '0;
      flags_q  <= '0;
      dflag_q  <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      done_q   <= done_d;
      flags_q  <= flags_d;
      dflag_q  <= dflag_d;
    end
  end

  assign xfer_strobe_o = strobe_q;
  assign done_flags_o  = flags_q;
  assign dma_flag_o    = dflag_q;
  assign irq_o         = dflag_q & irq_en_i;
endmodule

// File: rtl/dma_trig_ctrl_chk.sv
module dma_trig_ctrl_chk #(
  parameter int NCH = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] xfer_strobe_o,
  input logic [NCH-1:0] armed_o,
  input logic [NCH-1:0] done_flags_o,
  input logic           dma_flag_o,
  input logic           flag_clr_wr_i,
  input logic [NCH-1:0] flag_clr_i,
  input logic           cpu_flag_clr_i
);
  logic [NCH-1:0] clr_bits;
  assign clr_bits = flag_clr_wr_i ? flag_clr_i : '0;

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xfer_strobe_o));

  // R3
  strobe_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_strobe_o & ~$past(armed_o)) == '0);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(done_flags_o) & ~$past(clr_bits)) & ~done_flags_o) == '0);

  // R8
  flag_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_flags_o & ~$past(done_flags_o)) & ~xfer_strobe_o) == '0);

  // R10
  dflag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_flag_o) |-> (xfer_strobe_o != '0));

  // R10
  dflag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_flag_o) |-> $past(cpu_flag_clr_i));
endmodule

bind dma_trig_ctrl dma_trig_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_strobe_o(xfer_strobe_o), .armed_o(armed_o),
  .done_flags_o(done_flags_o), .dma_flag_o(dma_flag_o),
  .flag_clr_wr_i(flag_clr_wr_i), .flag_clr_i(flag_clr_i),
  .cpu_flag_clr_i(cpu_flag_clr_i));

// File: tb/dma_trig_ctrl_tb.sv
module dma_trig_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        arm_wr, swreq_wr, cfg_wr, cfg_msk, flag_clr_wr, cpu_flag_clr, irq_en;
  logic [7:0]  arm_data, cfg_len;
  logic [6:0]  swreq, flag_clr, strobe, armed, flags;
  logic [2:0]  cfg_ch;
  logic [4:0]  cfg_trig;
  logic [11:0] periph;
  logic        pin_rise, pin_fall, dma_flag, irq;
  int          checks = 0, errors = 0;

  dma_trig_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .arm_wr_i(arm_wr), .arm_data_i(arm_data),
    .swreq_wr_i(swreq_wr), .swreq_i(swreq), .cfg_wr_i(cfg_wr), .cfg_ch_i(cfg_ch),
    .cfg_trig_i(cfg_trig), .cfg_len_i(cfg_len), .cfg_msk_i(cfg_msk),
    .flag_clr_wr_i(flag_clr_wr), .flag_clr_i(flag_clr), .cpu_flag_clr_i(cpu_flag_clr),
    .irq_en_i(irq_en), .periph_trig_i(periph), .pin_rise_i(pin_rise),
    .pin_fall_i(pin_fall), .xfer_strobe_o(strobe), .armed_o(armed),
    .done_flags_o(flags), .dma_flag_o(dma_flag), .irq_o(irq));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int ch, input int trig, input int len, input bit m);
    cfg_wr = 1'b1; cfg_ch = 3'(ch); cfg_trig = 5'(trig); cfg_len = 8'(len); cfg_msk = m;
    cyc();
    cfg_wr = 1'b0;
  endtask

  task automatic arm(input logic [7:0] d);
    arm_wr = 1'b1; arm_data = d;
    cyc();
    arm_wr = 1'b0;
  endtask

  task automatic sw(input logic [6:0] m);
    swreq_wr = 1'b1; swreq = m;
    cyc();
    swreq_wr = 1'b0; swreq = '0;
  endtask

  task automatic pulse(input logic [11:0] p);
    periph = p;
    cyc();
    periph = '0;
  endtask

  task automatic clr_all();
    flag_clr_wr = 1'b1; flag_clr = 7'h7f; cpu_flag_clr = 1'b1;
    cyc();
    flag_clr_wr = 1'b0; flag_clr = '0; cpu_flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 armed", armed, 0);
    chk("R12 strobe", strobe, 0);
    chk("R12 flags", flags, 0);
    chk("R12 dflag/irq", {dma_flag, irq}, 0);
  endtask

  task automatic t_arm();
    arm(8'h03);
    chk("R1 arm 0x03", armed, 7'h03);
    arm(8'h81);
    chk("R2 abort 0x81", armed, 7'h02);
    arm(8'h82);
    chk("R2 abort ch1", armed, 7'h00);
  endtask

  task automatic t_sw_none();
    cfg(2, 0, 1, 1'b0);
    arm(8'h04);
    pulse(12'hfff);
    cyc(2);
    chk("R4 hw ignored with code 0", strobe, 0);
    sw(7'h04);
    chk("R4 no strobe before second edge", strobe, 0);
    cyc();
    chk("R4 sw strobe", strobe, 7'h04);
    chk("R9 flag set with mask 0", flags[2], 1);
    chk("R10 no dflag with mask 0", dma_flag, 0);
    cyc();
    chk("R4 one-cycle strobe", strobe, 0);
    chk("R8 disarm on completion", armed[2], 0);
  endtask

  task automatic t_unarmed();
    cfg(3, 0, 1, 1'b0);
    sw(7'h08);
    cyc(2);
    chk("R3 unarmed sw ignored", strobe, 0);
    arm(8'h08);
    cyc(2);
    chk("R3 no stale request after arm", strobe, 0);
    arm(8'h88);
  endtask

  task automatic t_periph();
    cfg(1, 7, 1, 1'b0);
    arm(8'h02);
    pulse(12'h010);
    cyc();
    chk("R6 wrong peripheral ignored", strobe, 0);
    pulse(12'h020);
    cyc();
    chk("R6 code 7 uses peripheral 5", strobe, 7'h02);
    cfg(1, 20, 1, 1'b0);
    arm(8'h02);
    pulse(12'hfff);
    cyc(2);
    chk("R6 unused code never fires", strobe, 0);
    chk("R6 still armed", armed[1], 1);
    arm(8'h82);
  endtask

  task automatic t_count_irq();
    clr_all();
    irq_en = 1'b0;
    cfg(0, 0, 3, 1'b1);
    arm(8'h01);
    sw(7'h01); cyc();
    chk("R8 first of three", {strobe, flags[0], armed[0]}, {7'h01, 1'b0, 1'b1});
    sw(7'h01); cyc();
    chk("R8 second of three", {strobe, flags[0], armed[0]}, {7'h01, 1'b0, 1'b1});
    sw(7'h01); cyc();
    chk("R8 third completes", {strobe, flags[0]}, {7'h01, 1'b1});
    chk("R10 dflag set, irq gated", {dma_flag, irq}, 2'b10);
    cyc();
    chk("R8 disarmed", armed[0], 0);
    irq_en = 1'b1;
    cyc();
    chk("R10 irq with enable", irq, 1);
    cpu_flag_clr = 1'b1; cyc(); cpu_flag_clr = 1'b0;
    chk("R10 dflag cleared", {dma_flag, irq}, 0);
    irq_en = 1'b0;
    cfg(0, 0, 0, 1'b0);
    arm(8'h01);
    sw(7'h01); cyc();
    chk("R8 length 0 completes at once", {strobe, armed[0]}, {7'h01, 1'b0});
  endtask

  task automatic t_flags();
    clr_all();
    cfg(2, 0, 1, 1'b0);
    cfg(4, 0, 1, 1'b0);
    arm(8'h14);
    sw(7'h14); cyc(2);
    chk("R9 two flags set", flags, 7'h14);
    flag_clr_wr = 1'b1; flag_clr = 7'h10; cyc(); flag_clr_wr = 1'b0; flag_clr = '0;
    chk("R9 w1c clears only bit 4", flags, 7'h04);
    arm(8'h04);
    swreq_wr = 1'b1; swreq = 7'h04; cyc();
    swreq_wr = 1'b0; swreq = '0;
    flag_clr_wr = 1'b1; flag_clr = 7'h04; cyc();
    flag_clr_wr = 1'b0; flag_clr = '0;
    chk("R9 set wins over clear", flags[2], 1);
  endtask

  task automatic t_chain();
    cfg(0, 0, 1, 1'b0);
    cfg(1, 1, 1, 1'b0);
    arm(8'h03);
    sw(7'h01); cyc();
    chk("R5 ch0 strobe", strobe, 7'h01);
    cyc();
    chk("R5 gap cycle", strobe, 0);
    cyc();
    chk("R5 chained ch1 strobe", strobe, 7'h02);
    cfg(0, 1, 1, 1'b0);
    cfg(6, 0, 1, 1'b0);
    arm(8'h41);
    sw(7'h40); cyc();
    chk("R5 ch6 strobe", strobe, 7'h40);
    cyc(2);
    chk("R5 ch0 code 1 never fires", {strobe, armed[0]}, {7'h00, 1'b1});
    arm(8'h81);
  endtask

  task automatic t_pins();
    cfg(2, 14, 1, 1'b0);
    cfg(3, 15, 1, 1'b0);
    arm(8'h0c);
    pin_rise = 1'b1;
    cyc(3);
    chk("R7 rise not yet", strobe, 0);
    cyc();
    chk("R7 rising edge strobe", strobe, 7'h04);
    pin_fall = 1'b0;
    cyc(3);
    chk("R7 fall not yet", strobe, 0);
    cyc();
    chk("R7 falling edge strobe", strobe, 7'h08);
    arm(8'h0c);
    pin_fall = 1'b1;
    cyc(6);
    chk("R7 wrong edges and held levels ignored", {strobe, armed[3:2]}, {7'h00, 2'b11});
    arm(8'h8c);
  endtask

  task automatic t_arb();
    for (int c = 0; c < 4; c++) cfg(c, 0, 1, 1'b0);
    arm(8'h07);
    sw(7'h07); cyc();
    chk("R11 lowest first", strobe, 7'h01);
    cyc();
    chk("R11 then ch1", strobe, 7'h02);
    cyc();
    chk("R11 then ch2", strobe, 7'h04);
    arm(8'h09);
    swreq_wr = 1'b1; swreq = 7'h09; cyc();
    swreq_wr = 1'b0; swreq = '0;
    arm_wr = 1'b1; arm_data = 8'h88; cyc(); arm_wr = 1'b0;
    chk("R2 ch0 served during abort", {strobe, armed}, {7'h01, 7'h00});
    cyc();
    chk("R2 aborted pending dropped", strobe, 0);
    cyc();
    chk("R2 still nothing", strobe, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    arm_wr = 0; arm_data = 0; swreq_wr = 0; swreq = 0; cfg_wr = 0; cfg_ch = 0;
    cfg_trig = 0; cfg_len = 0; cfg_msk = 0; flag_clr_wr = 0; flag_clr = 0;
    cpu_flag_clr = 0; irq_en = 0; periph = 0; pin_rise = 0; pin_fall = 1;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_arm();
    t_sw_none();
    t_unarmed();
    t_periph();
    t_count_irq();
    t_flags();
    t_chain();
    t_pins();
    t_arb();
    summary();
    $finish;
  end
endmodule